// File: doc/BRIEF.md
# Dual Halfword Parallel Multiplier

This block takes a 32-bit register operand and a 32-bit second operand and treats each as two 16-bit halves. The two halves are multiplied lane by lane in parallel, with both lanes signed or both unsigned, as the operation select chooses. Each lane keeps its full 32-bit product. The product of the upper halves is returned on the destination result port. The surrounding pipeline writes that value back into the same register that supplied the first operand. The product of the lower halves goes into a secondary result register that belongs to the block.

An operation starts with a one-cycle strobe. Both results, and a one-cycle completion pulse, appear on the first clock edge after the strobe. Nothing accumulates, and no overflow is flagged. Software can read the secondary register at all times. It can also load the register through a write port while the block is idle.

Top module: `dhmul_top`

## Requirements
- R1: The select input is 4 bits wide. Value 8 selects signed lanes and value 9 selects unsigned lanes. A start strobe with any other select value is ignored: no completion pulse follows and neither result changes.
- R2: The lower lanes (operand bits 15:0) are multiplied, sign-extended for select 8 and zero-extended for select 9, and the product is loaded into the secondary register, read on `sec_q`.
- R3: The upper lanes (operand bits 31:16) are multiplied with the same extension, and the product is presented on `dest_q`.
- R4: Each lane product is the exact 32-bit result, with no truncation or saturation (for example, signed -32768 x -32768 gives 0x40000000 and unsigned 0xFFFF x 0xFFFF gives 0xFFFE0001).
- R5: An accepted start updates `dest_q` and `sec_q` on the next clock edge. On that same edge `done` rises for exactly one cycle.
- R6: A start strobe in the cycle where `done` is high is ignored: `done` falls on the next edge and both results keep their values.
- R7: Synchronous reset clears `dest_q` and `sec_q` to zero and holds `done` low.
- R8: A software write while the block is idle (no `done`, no start) loads `sw_wdata` into the secondary register, and the new value is visible on `sec_q` after the next edge.
- R9: A software write is dropped when `done` is high. When a start is accepted in the same cycle as a write, the lane product wins.
- R10: With no start and no software write, both result outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle operation strobe |
| op_sel | input | 4 | Operation select: 8 signed, 9 unsigned |
| reg_opnd | input | 32 | Register operand, also the write-back target |
| aux_opnd | input | 32 | Second operand |
| sw_we | input | 1 | Software write enable for the secondary register |
| sw_wdata | input | 32 | Software write data |
| dest_q | output | 32 | Upper-lane product for write-back |
| sec_q | output | 32 | Secondary register (lower-lane product) |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest cases to reach are the collisions: a start strobe arriving in the completion cycle of an earlier operation, and a software write landing in the same cycle as an accepted start or a completion pulse. The bench reaches them by driving the second request on the falling edge inside the cycle where `done` is high, or alongside a start. It then checks on the following cycle that the first operation's results and the pulse width are untouched. Lane extremes (0x8000 and 0xFFFF) in both signed and unsigned modes cover the full-width product rule.

// File: rtl/dhm_pkg.sv
package dhm_pkg;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;
    localparam int LANES  = 2;

    typedef enum logic [3:0] {
        OP_DMUL_S = 4'd8,
        OP_DMUL_U = 4'd9
    } op_sel_e;

    typedef struct packed {
        logic              sgn;
        logic [HALF_W-1:0] x;
        logic [HALF_W-1:0] y;
    } lane_req_t;

    function automatic logic sel_known(input logic [3:0] s);
        return (s == OP_DMUL_S) || (s == OP_DMUL_U);
    endfunction

    function automatic logic sel_signed(input logic [3:0] s);
        return s == OP_DMUL_S;
    endfunction
endpackage

// File: rtl/dhm_lane.sv
module dhm_lane
    import dhm_pkg::*;
(
    input  lane_req_t         req,
    output logic [WORD_W-1:0] prod
);
    logic signed [HALF_W:0]     xe;
    logic signed [HALF_W:0]     ye;
    logic signed [2*HALF_W+1:0] pfull;

    always_comb begin
        xe    = {req.sgn & req.x[HALF_W-1], req.x};
        ye    = {req.sgn & req.y[HALF_W-1], req.y};
        pfull = xe * ye;
        prod  = pfull[WORD_W-1:0];
    end
endmodule

// File: rtl/dhm_ctrl.sv
module dhm_ctrl
    import dhm_pkg::*;
(
    input  logic       start,
    input  logic [3:0] op_sel,
    input  logic       busy,
    input  logic       sw_we,
    output logic       accept,
    output logic       sgn,
    output logic       sw_take
);
    always_comb begin
        accept  = start && !busy && sel_known(op_sel);
        sgn     = sel_signed(op_sel);
        sw_take = sw_we && !busy && !accept;
    end
endmodule

// File: rtl/dhmul_top.sv
module dhmul_top
    import dhm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [3:0]        op_sel,
    input  logic [WORD_W-1:0] reg_opnd,
    input  logic [WORD_W-1:0] aux_opnd,
    input  logic              sw_we,
    input  logic [WORD_W-1:0] sw_wdata,
    output logic [WORD_W-1:0] dest_q,
    output logic [WORD_W-1:0] sec_q,
    output logic              done
);
    logic accept, sgn, sw_take;
    logic [WORD_W-1:0] lane_prod [LANES];

    dhm_ctrl u_ctrl (
        .start  (start),
        .op_sel (op_sel),
        .busy   (done),
        .sw_we  (sw_we),
        .accept (accept),
        .sgn    (sgn),
        .sw_take(sw_take)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lane_req_t req;
        always_comb begin
            req.sgn = sgn;
            req.x   = reg_opnd[l*HALF_W +: HALF_W];
            req.y   = aux_opnd[l*HALF_W +: HALF_W];
        end
        dhm_lane u_lane (.req(req), .prod(lane_prod[l]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dest_q <= '0;
            sec_q  <= '0;
            done   <= 1'b0;
        end else begin
            done <= accept;
            if (accept) begin
                dest_q <= lane_prod[1];
                sec_q  <= lane_prod[0];
            end else if (sw_take) begin
                sec_q  <= sw_wdata;
            end
        end
    end

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (dest_q == '0 && sec_q == '0 && !done));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5
    done_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !done && (op_sel == 4'd8 || op_sel == 4'd9)) |=> done);

    // R1
    bad_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (start && op_sel != 4'd8 && op_sel != 4'd9) |=> !done);

    // R6
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> ($stable(dest_q) && $stable(sec_q)));

    // R8
    sw_write_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_we && !done && !start) |=> (sec_q == $past(sw_wdata)));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!start && !sw_we) |=> ($stable(dest_q) && $stable(sec_q)));
endmodule

// File: tb/dhmul_top_test.sv
`timescale 1ns/1ps
module dhmul_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  op_sel = 4'd0;
    logic [31:0] reg_opnd = '0, aux_opnd = '0, sw_wdata = '0;
    logic        sw_we = 1'b0;
    logic [31:0] dest_q, sec_q;
    logic        done;
    int total = 0, bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dhmul_top uut (.clk(clk), .rst(rst), .start(start), .op_sel(op_sel),
        .reg_opnd(reg_opnd), .aux_opnd(aux_opnd), .sw_we(sw_we),
        .sw_wdata(sw_wdata), .dest_q(dest_q), .sec_q(sec_q), .done(done));

    function automatic logic [31:0] ref_mul(input logic [15:0] x,
                                            input logic [15:0] y,
                                            input bit s);
        longint p;
        if (s) p = longint'($signed(x)) * longint'($signed(y));
        else   p = longint'(x) * longint'(y);
        return p[31:0];
    endfunction

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive a start at a falling edge; returns at the next falling edge
    task automatic pulse_op(input logic [31:0] a, input logic [31:0] b,
                            input logic [3:0] s);
        @(negedge clk);
        reg_opnd = a; aux_opnd = b; op_sel = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset;
        chk("R7 dest", dest_q, 32'h0);
        chk("R7 sec", sec_q, 32'h0);
        chk("R7 done", {31'b0, done}, 32'h0);
    endtask

    task automatic t_op(input string tag, input logic [31:0] a,
                        input logic [31:0] b, input bit s);
        pulse_op(a, b, s ? 4'd8 : 4'd9);
        chk({tag, " R5 done"}, {31'b0, done}, 32'h1);
        chk({tag, " R3 hi"}, dest_q, ref_mul(a[31:16], b[31:16], s));
        chk({tag, " R2 lo"}, sec_q, ref_mul(a[15:0], b[15:0], s));
        @(negedge clk);
        chk({tag, " R5 one-cycle"}, {31'b0, done}, 32'h0);
    endtask

    task automatic t_extremes;
        t_op("R4 s", 32'h8000_8000, 32'h8000_7FFF, 1'b1);
        chk("R4 s hi", dest_q, 32'h4000_0000);
        chk("R4 s lo", sec_q, 32'hC000_8000);
        t_op("R4 u", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        chk("R4 u hi", dest_q, 32'hFFFE_0001);
        chk("R4 u lo", sec_q, 32'hFFFE_0001);
    endtask

    task automatic t_busy;
        logic [31:0] eh, el;
        eh = ref_mul(16'h0007, 16'h0009, 1'b1);
        el = ref_mul(16'h0002, 16'h0003, 1'b1);
        pulse_op(32'h0007_0002, 32'h0009_0003, 4'd8);
        reg_opnd = 32'h1111_1111; aux_opnd = 32'h2222_2222;
        op_sel = 4'd9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R6 done falls", {31'b0, done}, 32'h0);
        chk("R6 dest kept", dest_q, eh);
        chk("R6 sec kept", sec_q, el);
    endtask

    task automatic t_badsel;
        logic [31:0] dh, dl;
        dh = dest_q; dl = sec_q;
        pulse_op(32'h0005_0005, 32'h0005_0005, 4'hB);
        chk("R1 no done", {31'b0, done}, 32'h0);
        chk("R1 dest", dest_q, dh);
        chk("R1 sec", sec_q, dl);
    endtask

    task automatic t_sw;
        @(negedge clk);
        sw_we = 1'b1; sw_wdata = 32'hA5A5_1234;
        @(negedge clk);
        sw_we = 1'b0;
        chk("R8 sw write", sec_q, 32'hA5A5_1234);
        // write during done is dropped
        pulse_op(32'h0001_0004, 32'h0001_0004, 4'd9);
        sw_we = 1'b1; sw_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        sw_we = 1'b0;
        chk("R9 write in done", sec_q, 32'h0000_0010);
        // write with an accepted start: product wins
        @(negedge clk);
        reg_opnd = 32'h0002_0006; aux_opnd = 32'h0003_0007; op_sel = 4'd9;
        start = 1'b1; sw_we = 1'b1; sw_wdata = 32'h0BAD_F00D;
        @(negedge clk);
        start = 1'b0; sw_we = 1'b0;
        chk("R9 start wins", sec_q, 32'h0000_002A);
        chk("R9 start wins dest", dest_q, 32'h0000_0006);
    endtask

    task automatic t_hold;
        logic [31:0] dh, dl;
        @(negedge clk);
        dh = dest_q; dl = sec_q;
        reg_opnd = 32'h7777_7777; aux_opnd = 32'h3333_3333; op_sel = 4'd8;
        repeat (4) @(negedge clk);
        chk("R10 dest hold", dest_q, dh);
        chk("R10 sec hold", sec_q, dl);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_op("R1 signed", 32'h0003_FFFE, 32'hFFFF_0005, 1'b1);
        t_op("R1 unsigned", 32'h0003_FFFE, 32'hFFFF_0005, 1'b0);
        t_op("mix", 32'h1234_8001, 32'hF00D_0042, 1'b1);
        t_extremes();
        t_busy();
        t_badsel();
        t_sw();
        t_hold();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule